// File: doc/BRIEF.md
# Four-Channel Event Timer Bank with Timestamp Counter

This block holds four event timers and one free-running timestamp counter behind a simple word-addressed read/write bus. A single shared control word carries each event channel's enable bit, its repeat/single-fire mode bit and a 2-bit decade timebase (1 us, 10 us, 100 us or 1 ms). The same word also carries the timestamp counter's enable bit and its 3-bit timebase, which adds the raw system clock as an option. One shared prescaler turns the system clock into the four tick strobes. It divides by a parameter giving clocks per microsecond, then by three cascaded divide-by-ten stages.

Each event channel has its own register. Writing it loads a 16-bit starting count and restarts the countdown. Reading it returns the remaining count in the upper half and the programmed count in the lower half. When the countdown expires, the channel raises a one-clock interrupt pulse, so a rising-edge interrupt controller sees one event. In periodic mode the channel then reloads and keeps firing. In single-fire mode it stops until software writes a new count. Software reads the 64-bit timestamp as two 32-bit words.

Top module: `tmr_bank`

## Requirements
- R1: Word address 0 is the control word. Bits [1:0], [3:2], [5:4] and [7:6] hold the timebase of channels 0 to 3. Bits [10:8] hold the timestamp timebase. Bits 12 to 15 are the mode bits of channels 0 to 3 (1 = periodic, 0 = single-fire). Bits 16 to 19 enable channels 0 to 3, and bit 20 enables the timestamp. All other bits read as 0, whatever was written.
- R2: Event timebase code 0 gives a 1 us tick, 1 gives 10 us, 2 gives 100 us and 3 gives 1 ms. One microsecond is CLKS_PER_US system clocks.
- R3: An enabled periodic channel programmed with N (1 to 0xFFFF) raises its interrupt once every N ticks of its timebase, for as long as it stays enabled.
- R4: A single-fire channel raises its interrupt exactly once, and its remaining count then reads 0. Toggling its enable bit does not make it fire again; only a new count write does.
- R5: Each expiry is signalled by an interrupt pulse exactly one clock wide.
- R6: Clearing a channel's enable bit freezes its remaining count and suppresses its interrupt, and leaves its mode and timebase bits unchanged. Setting the bit again resumes the countdown from the frozen value.
- R7: Channel n (0 to 3) sits at word address n+1. A write loads bits [15:0] as both the programmed count and the remaining count, and the countdown restarts from there. If the write lands in the same cycle as an expiry, the write wins and no pulse is raised. A read returns the remaining count in [31:16] and the programmed count in [15:0].
- R8: Writing a count of 0 leaves the channel idle. It raises no interrupt even when enabled.
- R9: When enabled, the 64-bit timestamp counter adds one per system clock for code 0, and per 1 us, 10 us, 100 us or 1 ms tick for codes 1 to 4. Codes 5 to 7 and a clear enable bit hold its value.
- R10: Word address 5 reads timestamp bits [31:0] and word address 6 reads bits [63:32]. Word address 7 reads as 0. Reads are combinational in the cycle the address is presented.
- R11: After reset, the control word, every channel register and the timestamp read 0, and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (qualified by bus_sel) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 4 | Per-channel one-clock expiry pulses |

## Verification
The bench measures the exact interval between successive pulses for every timebase code, so an off-by-one in a decade divider or in the countdown shows up as a period one tick too long or too short. It drives a single-fire channel through an enable toggle, which catches a design that rearms on enable instead of on a count write. It freezes a channel mid-count and compares readbacks, which catches counting while disabled or resetting on resume. It also programs a zero count and checks for the absence of pulses, which catches a down-counter that wraps to 0xFFFF and eventually fires. On the timestamp it checks the raw-clock increment rate and confirms that the undefined codes hold the value instead of aliasing to a tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH      = 4;
    localparam int CNT_W    = 16;
    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int NBASE    = 4;
    localparam int STAMP_W  = 64;
    localparam int DEC_LAST = 9;

    localparam int EN_LSB      = 16;
    localparam int MODE_LSB    = 12;
    localparam int TS_EN_BIT   = 20;
    localparam int TS_BASE_LSB = 8;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_STLO = 3'd5;
    localparam logic [AW-1:0] A_STHI = 3'd6;

    localparam logic [DW-1:0] CTRL_MASK = 32'h001F_F7FF;

    typedef enum logic [1:0] {
        TB_1US   = 2'd0,
        TB_10US  = 2'd1,
        TB_100US = 2'd2,
        TB_1MS   = 2'd3
    } tbase_e;

    typedef struct packed {
        logic   en;
        logic   periodic;
        tbase_e base;
    } ch_cfg_t;

    typedef struct packed {
        logic       en;
        logic [2:0] base;
    } ts_cfg_t;

    function automatic ch_cfg_t ch_cfg_of(input logic [DW-1:0] c, input int idx);
        ch_cfg_t r;
        r.en       = c[EN_LSB + idx];
        r.periodic = c[MODE_LSB + idx];
        r.base     = tbase_e'(c[2*idx +: 2]);
        return r;
    endfunction

    function automatic ts_cfg_t ts_cfg_of(input logic [DW-1:0] c);
        ts_cfg_t r;
        r.en   = c[TS_EN_BIT];
        r.base = c[TS_BASE_LSB +: 3];
        return r;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int CLKS_PER_US = 100
) (
    input  logic             clk,
    input  logic             rst,
    output logic [NBASE-1:0] tick_o
);

    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst)                   pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
    end

    assign tick_o[0] = (pre_q == PRE_LAST);

    for (genvar s = 1; s < NBASE; s++) begin : g_dec
        logic [3:0] dec_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                dec_q <= '0;
            end else if (tick_o[s-1]) begin
                dec_q <= (dec_q == 4'(DEC_LAST)) ? 4'd0 : dec_q + 4'd1;
            end
        end

        assign tick_o[s] = tick_o[s-1] && (dec_q == 4'(DEC_LAST));

        // R2: each decade stage never leaves its 0..9 range
        a_r2_dec_range: assert property (@(posedge clk) disable iff (rst)
            dec_q <= 4'(DEC_LAST))
            else $error("decade stage out of range");
    end

endmodule

// File: rtl/tmr_event_chan.sv
module tmr_event_chan
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ch_cfg_t          cfg,
    input  logic [NBASE-1:0] ticks,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] remain_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] remain_q;
    logic             armed_q;
    logic             irq_q;
    logic             step;
    logic             fire;

    assign step = cfg.en && armed_q && ticks[cfg.base];
    assign fire = step && (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            remain_q <= '0;
            armed_q  <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= fire && !load_i;
            if (load_i) begin
                reload_q <= load_val;
                remain_q <= load_val;
                armed_q  <= (load_val != '0);
            end else if (fire) begin
                if (cfg.periodic) begin
                    remain_q <= reload_q;
                end else begin
                    remain_q <= '0;
                    armed_q  <= 1'b0;
                end
            end else if (step) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign remain_o = remain_q;
    assign reload_o = reload_q;
    assign irq_o    = irq_q;

    // R6: a pulse only follows a cycle in which the channel was enabled
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(cfg.en))
        else $error("interrupt from disabled channel");

    // R6: disabled channel holds its remaining count
    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && !load_i) |=> $stable(remain_q))
        else $error("count moved while disabled");

    // R4: single-fire expiry leaves the channel stopped at zero
    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (fire && !cfg.periodic && !load_i) |=> (remain_q == '0 && !armed_q))
        else $error("single-fire channel did not stop");

    // R3: periodic expiry restores the programmed count
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (fire && cfg.periodic && !load_i) |=> (remain_q == $past(reload_q)))
        else $error("periodic reload wrong");

    // R8: an idle channel raises nothing
    a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !load_i) |=> !irq_o)
        else $error("idle channel fired");

endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ts_cfg_t            cfg,
    input  logic [NBASE-1:0]   ticks,
    output logic [STAMP_W-1:0] count_o
);

    logic [STAMP_W-1:0] cnt_q;
    logic [2:0]         tick_idx;
    logic               inc;

    assign tick_idx = cfg.base - 3'd1;

    always_comb begin
        inc = 1'b0;
        if (cfg.en) begin
            if (cfg.base == 3'd0)                         inc = 1'b1;
            else if (cfg.base <= 3'(NBASE))               inc = ticks[tick_idx[1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    // R9: disabled timestamp holds
    a_r9_stamp_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> $stable(cnt_q))
        else $error("timestamp moved while disabled");

    // R9: timestamp never goes backwards
    a_r9_stamp_monotonic: assert property (@(posedge clk) disable iff (rst)
        cnt_q >= $past(cnt_q))
        else $error("timestamp decreased");

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int CLKS_PER_US = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic [3:0]    irq_o
);

    logic [DW-1:0]      ctrl_q;
    logic [NBASE-1:0]   ticks;
    logic [CNT_W-1:0]   remain_w [NCH];
    logic [CNT_W-1:0]   reload_w [NCH];
    logic [STAMP_W-1:0] stamp_w;
    logic               wr_en;

    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst)                              ctrl_q <= '0;
        else if (wr_en && bus_addr == A_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    tmr_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) u_ticks (
        .clk    (clk),
        .rst    (rst),
        .tick_o (ticks)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic load;
        assign load = wr_en && (bus_addr == AW'(i + 1));

        tmr_event_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg      (ch_cfg_of(ctrl_q, i)),
            .ticks    (ticks),
            .load_i   (load),
            .load_val (bus_wdata[CNT_W-1:0]),
            .remain_o (remain_w[i]),
            .reload_o (reload_w[i]),
            .irq_o    (irq_o[i])
        );
    end

    tmr_stamp u_stamp (
        .clk     (clk),
        .rst     (rst),
        .cfg     (ts_cfg_of(ctrl_q)),
        .ticks   (ticks),
        .count_o (stamp_w)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)      bus_rdata = ctrl_q;
        else if (bus_addr == A_STLO) bus_rdata = stamp_w[31:0];
        else if (bus_addr == A_STHI) bus_rdata = stamp_w[63:32];
        else begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == AW'(i + 1)) bus_rdata = {remain_w[i], reload_w[i]};
            end
        end
    end

    // R11: interrupts are low in the cycle after reset
    a_r11_irq_reset: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0))
        else $error("interrupt high after reset");

endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;

    localparam int CPU = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    tmr_bank #(.CLKS_PER_US(CPU)) u_tmr_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    // pulse monitor, sampled mid-cycle
    int unsigned cyc = 0;
    int unsigned pulses [4];
    int unsigned gap    [4];
    int unsigned last_t [4];
    int unsigned wide   [4];
    logic [3:0]  irq_prev = 4'd0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int c = 0; c < 4; c++) begin
            if (irq[c] === 1'b1) begin
                if (irq_prev[c]) wide[c] = wide[c] + 1;
                pulses[c] = pulses[c] + 1;
                gap[c]    = cyc - last_t[c];
                last_t[c] = cyc;
            end
        end
        irq_prev = irq;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] ch_ctrl(input int ch, input bit en, input bit per, input int code);
        logic [31:0] v;
        v = 32'd0;
        v[16+ch] = en;
        v[12+ch] = per;
        v[2*ch +: 2] = 2'(code);
        return v;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), d);
            check(d == 32'd0, "R11 reset readback", d, 0);
        end
        check(irq == 4'd0, "R11 irq low after reset", irq, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_read(3'd0, d);
        check(d == 32'h001F_F7FF, "R1 control writable bits", d, 32'h001F_F7FF);
        bus_write(3'd0, 32'd0);
        bus_read(3'd7, d);
        check(d == 32'd0, "R10 unused address reads 0", d, 0);
    endtask

    task automatic t_periodic(input int ch, input int code, input int cnt, input int exp_gap, input string req);
        int unsigned p0, w0;
        bus_write(3'd0, ch_ctrl(ch, 1, 1, code));
        bus_write(3'(ch + 1), 32'(cnt));
        p0 = pulses[ch];
        w0 = wide[ch];
        for (int i = 0; i < exp_gap * 5 && pulses[ch] < p0 + 3; i++) @(negedge clk);
        check(pulses[ch] >= p0 + 3, {req, " pulses seen"}, pulses[ch] - p0, 3);
        check(gap[ch] == exp_gap, {req, " R3 period"}, gap[ch], exp_gap);
        check(wide[ch] == w0, "R5 pulse one clock wide", wide[ch] - w0, 0);
        bus_write(3'd0, 32'd0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        int unsigned p0;
        bus_write(3'd0, ch_ctrl(0, 1, 0, 0));
        p0 = pulses[0];
        bus_write(3'd1, 32'd4);
        repeat (40) @(negedge clk);
        check(pulses[0] == p0 + 1, "R4 single-fire once", pulses[0] - p0, 1);
        bus_read(3'd1, d);
        check(d == 32'h0000_0004, "R4 R7 single-fire readback", d, 4);
        bus_write(3'd0, 32'd0);
        bus_write(3'd0, ch_ctrl(0, 1, 0, 0));
        repeat (40) @(negedge clk);
        check(pulses[0] == p0 + 1, "R4 enable toggle does not rearm", pulses[0] - p0, 1);
        bus_write(3'd0, 32'd0);
    endtask

    task automatic t_freeze();
        logic [31:0] d1, d2, d3, c;
        int unsigned p0;
        bus_write(3'd0, ch_ctrl(1, 1, 1, 0));
        bus_write(3'd2, 32'd1000);
        repeat (20) @(negedge clk);
        bus_write(3'd0, ch_ctrl(1, 0, 1, 0) | 32'h0000_0008);
        bus_read(3'd2, d1);
        p0 = pulses[1];
        repeat (50) @(negedge clk);
        bus_read(3'd2, d2);
        check(d1 == d2, "R6 count frozen while disabled", d2, d1);
        check(pulses[1] == p0, "R6 no pulse while disabled", pulses[1] - p0, 0);
        bus_read(3'd0, c);
        check(c == 32'h0000_2008, "R6 mode and timebase kept", c, 32'h2008);
        bus_write(3'd0, ch_ctrl(1, 1, 1, 0));
        repeat (20) @(negedge clk);
        bus_read(3'd2, d3);
        check(d3[31:16] < d1[31:16] && d3[31:16] + 16 > d1[31:16],
              "R6 resumes from frozen value", d3[31:16], d1[31:16]);
        bus_write(3'd0, 32'd0);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        int unsigned p0;
        bus_write(3'd0, ch_ctrl(2, 1, 1, 0));
        p0 = pulses[2];
        bus_write(3'd3, 32'd0);
        repeat (100) @(negedge clk);
        check(pulses[2] == p0, "R8 zero count never fires", pulses[2] - p0, 0);
        bus_read(3'd3, d);
        check(d == 32'd0, "R8 zero count readback", d, 0);
        bus_write(3'd0, 32'd0);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        int unsigned p0;
        bus_write(3'd0, ch_ctrl(3, 1, 1, 0));
        bus_write(3'd4, 32'd50);
        p0 = pulses[3];
        repeat (20) @(negedge clk);
        check(pulses[3] == p0, "R7 no early pulse", pulses[3] - p0, 0);
        bus_write(3'd4, 32'd5);
        bus_read(3'd4, d);
        check(d[15:0] == 16'd5, "R7 programmed count readback", d[15:0], 5);
        check(d[31:16] == 16'd5 || d[31:16] == 16'd4, "R7 restart count", d[31:16], 5);
        repeat (12) @(negedge clk);
        check(pulses[3] == p0 + 1, "R7 restart fires from new count", pulses[3] - p0, 1);
        bus_write(3'd0, 32'd0);
    endtask

    task automatic t_stamp();
        logic [31:0] a, b, h;
        bus_write(3'd0, 32'h0010_0000);
        bus_read(3'd5, a);
        repeat (9) @(negedge clk);
        bus_read(3'd5, b);
        check(b - a == 10, "R9 raw clock rate", b - a, 10);
        bus_write(3'd0, 32'h0010_0100);
        bus_read(3'd5, a);
        repeat (19) @(negedge clk);
        bus_read(3'd5, b);
        check(b - a == 10, "R9 1us rate", b - a, 10);
        bus_write(3'd0, 32'h0010_0500);
        bus_read(3'd5, a);
        repeat (19) @(negedge clk);
        bus_read(3'd5, b);
        check(b == a, "R9 undefined code holds", b - a, 0);
        bus_write(3'd0, 32'h0000_0000);
        bus_read(3'd5, a);
        repeat (19) @(negedge clk);
        bus_read(3'd5, b);
        check(b == a && a != 0, "R9 disabled holds", b, a);
        bus_read(3'd6, h);
        check(h == 32'd0, "R10 high word", h, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_periodic(0, 0, 3, 3 * CPU, "R2 code0");
        t_periodic(1, 1, 2, 2 * 10 * CPU, "R2 code1");
        t_periodic(2, 2, 1, 100 * CPU, "R2 code2");
        t_periodic(3, 3, 1, 1000 * CPU, "R2 code3");
        t_oneshot();
        t_freeze();
        t_zero();
        t_restart();
        t_stamp();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule